// File: doc/BRIEF.md
# Serial Command/Response Slave with Selectable Read Pin

This block is the serial-peripheral slave that sits between an external host and a command-driven core. The host pulls `sen_n` low, then clocks in a one-byte control code on `sdio_in`, most significant bit first, on the rising edges of `sclk`. The control code picks one of five actions:

- write an eight-byte command packet;
- read one status byte on the main data pin;
- read sixteen bytes on the main data pin;
- read one status byte on the alternate pin;
- read sixteen bytes on the alternate pin.

The block runs on the system clock `clk`. It samples `sclk`, `sen_n` and `sdio_in` as synchronous levels and finds the serial clock edges by comparing each `sclk` sample with the one before it.

A write commits only when exactly 64 data bits have arrived before `sen_n` returns high. A commit latches the packet into `cmd_buf` and pulses `cmd_strobe` for one clock. Any other bit count is treated as an abort: the packet is dropped and `cmd_buf` keeps its old value.

Read data comes from the core's `rsp_buf` as a bit stream, and it changes on falling `sclk` edges so that the host can sample it on rising edges. Only the pin that the control code selected is enabled, and only during the read phase.

The controller has five states:
- `ST_IDLE`: no transaction.
- `ST_CTRL`: collecting the control byte.
- `ST_WDATA`: collecting write data.
- `ST_RDATA`: shifting out read data.
- `ST_SKIP`: an illegal control code was received, so the rest of the transaction is ignored.

The transitions are:
- `ST_IDLE` to `ST_CTRL` when `sen_n` is seen low.
- `ST_CTRL` on its eighth rising edge, to `ST_WDATA`, `ST_RDATA` or `ST_SKIP`, according to the completed byte.
- Every other state back to `ST_IDLE` whenever `sen_n` is seen high.

Top module: `spi_cr_slave`

## Requirements
- R1: After reset, `sdio_oe`, `alt_oe`, `sdio_out`, `alt_out` and `cmd_strobe` are 0, and `cmd_buf` is all zeros.
- R2: Once `sen_n` has been low for at least one clock, the next eight `sclk` rising edges capture the control byte from `sdio_in`, MSB first.
- R3: Control byte 0x48 followed by exactly 64 data bits and then `sen_n` high produces a one-clock `cmd_strobe` in the clock after `sen_n` is seen high. At that point `cmd_buf` holds the packet, with the first bit received in bit 63, so the first byte occupies [63:56].
- R4: After 0x48, any data bit count other than 64 at termination produces no strobe and leaves `cmd_buf` unchanged.
- R5: Control byte 0x80 shifts out 8 bits and 0xC0 shifts out 128 bits on `sdio_out`. Stream bit j is `rsp_buf[127-j]`, so status is `rsp_buf[127:120]`, sent MSB first.
- R6: Control bytes 0xA0 (8 bits) and 0xE0 (128 bits) send the same stream on `alt_out` instead.
- R7: Read data changes only on `sclk` falling edges. The selected output is 0 before the first fall and after the last stream bit.
- R8: The enable of the pin chosen by the control byte is high from the eighth control rising edge until `sen_n` is seen high. The other enable stays low, and the two enables are never high together.
- R9: A control byte other than the five legal codes leaves both enables low and produces no strobe for the rest of the transaction.
- R10: `sen_n` high ends a transaction in any state. An `sclk` rising edge seen in the same clock as `sen_n` high is not counted.
- R11: `sclk` and `sdio_in` activity while `sen_n` is high changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen_n | input | 1 | Transaction enable, active low |
| sclk | input | 1 | Serial clock level |
| sdio_in | input | 1 | Serial data from host |
| sdio_out | output | 1 | Read data on main pin |
| sdio_oe | output | 1 | Drive enable, main pin |
| alt_out | output | 1 | Read data on alternate pin |
| alt_oe | output | 1 | Drive enable, alternate pin |
| rsp_buf | input | 128 | Response bytes from core, byte 0 in [127:120] |
| cmd_buf | output | 64 | Last committed command packet |
| cmd_strobe | output | 1 | One-clock pulse on commit |

## Verification
Termination and a serial clock edge can arrive in the same system clock. The case that matters is a rising edge landing on the clock where `sen_n` is first seen high. The bench provokes this by raising `sen_n` and `sclk` at the same instant at the end of write transactions. Once with 64 bits already received the result must be a strobe, since the 65th edge is not counted. Once with 63 bits the result must be no strobe, since the 64th edge is not counted either. A reference model compares every output on every clock. In that model, termination always overrides the edge.

// File: rtl/spi_cr_pkg.sv
package spi_cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } cr_state_e;

    localparam logic [7:0] OP_WRITE     = 8'h48;
    localparam logic [7:0] OP_STAT_MAIN = 8'h80;
    localparam logic [7:0] OP_RESP_MAIN = 8'hC0;
    localparam logic [7:0] OP_STAT_ALT  = 8'hA0;
    localparam logic [7:0] OP_RESP_ALT  = 8'hE0;

    typedef struct packed {
        logic legal;
        logic is_write;
        logic use_alt;
        logic full_resp;
    } ctrl_dec_t;

    function automatic ctrl_dec_t decode_ctrl(input logic [7:0] code);
        ctrl_dec_t d;
        d = '0;
        unique case (code)
            OP_WRITE:     d = '{legal: 1'b1, is_write: 1'b1, use_alt: 1'b0, full_resp: 1'b0};
            OP_STAT_MAIN: d = '{legal: 1'b1, is_write: 1'b0, use_alt: 1'b0, full_resp: 1'b0};
            OP_RESP_MAIN: d = '{legal: 1'b1, is_write: 1'b0, use_alt: 1'b0, full_resp: 1'b1};
            OP_STAT_ALT:  d = '{legal: 1'b1, is_write: 1'b0, use_alt: 1'b1, full_resp: 1'b0};
            OP_RESP_ALT:  d = '{legal: 1'b1, is_write: 1'b0, use_alt: 1'b1, full_resp: 1'b1};
            default:      d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spi_cr_edge.sv
module spi_cr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_in;
    end

    assign rise = sclk_in & ~sclk_q;
    assign fall = ~sclk_in & sclk_q;
endmodule

// File: rtl/spi_cr_shreg.sv
module spi_cr_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (shift) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/spi_cr_txbit.sv
module spi_cr_txbit #(
    parameter int NBITS = 128,
    parameter int CW    = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CW-1:0]    limit,
    input  logic [NBITS-1:0] stream,
    output logic             bit_o
);
    logic [CW-1:0]    idx;
    logic [NBITS-1:0] shifted;

    assign shifted = stream << idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            bit_o <= 1'b0;
        end else if (clr) begin
            idx   <= '0;
            bit_o <= 1'b0;
        end else if (adv) begin
            if (idx < limit) begin
                bit_o <= shifted[NBITS-1];
                idx   <= idx + 1'b1;
            end else begin
                bit_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_cr_slave.sv
module spi_cr_slave
    import spi_cr_pkg::*;
#(
    parameter int CMD_BYTES = 8,
    parameter int RSP_BYTES = 16,
    parameter int STAT_BYTES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sen_n,
    input  logic                   sclk,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   alt_out,
    output logic                   alt_oe,
    input  logic [RSP_BYTES*8-1:0] rsp_buf,
    output logic [CMD_BYTES*8-1:0] cmd_buf,
    output logic                   cmd_strobe
);
    localparam int CMD_BITS  = CMD_BYTES * 8;
    localparam int RSP_BITS  = RSP_BYTES * 8;
    localparam int STAT_BITS = STAT_BYTES * 8;
    localparam int CW        = $clog2(RSP_BITS + 1);
    localparam int WCW       = $clog2(CMD_BITS + 2);

    cr_state_e state, state_n;

    logic             sclk_rise, sclk_fall;
    logic [3:0]       ctrl_cnt;
    logic [WCW-1:0]   wr_cnt;
    logic             use_alt_q, full_q;
    logic [7:0]       ctrl_sh;
    logic [CMD_BITS-1:0] cmd_sh;
    logic             tx_bit;
    logic             commit;
    logic             rise_act;
    logic             ctrl_done;
    ctrl_dec_t        dec;
    logic [CW-1:0]    tx_limit;

    spi_cr_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk),
        .rise    (sclk_rise),
        .fall    (sclk_fall)
    );

    assign rise_act  = sclk_rise & ~sen_n;
    assign ctrl_done = (state == ST_CTRL) && rise_act && (ctrl_cnt == 4'd7);
    assign dec       = decode_ctrl({ctrl_sh[6:0], sdio_in});
    assign commit    = (state == ST_WDATA) && sen_n && (wr_cnt == WCW'(CMD_BITS));
    assign tx_limit  = full_q ? CW'(RSP_BITS) : CW'(STAT_BITS);

    spi_cr_shreg #(.W(8)) u_ctrl_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .shift ((state == ST_CTRL) && rise_act),
        .din   (sdio_in),
        .q     (ctrl_sh)
    );

    spi_cr_shreg #(.W(CMD_BITS)) u_cmd_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .shift ((state == ST_WDATA) && rise_act),
        .din   (sdio_in),
        .q     (cmd_sh)
    );

    spi_cr_txbit #(.NBITS(RSP_BITS), .CW(CW)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state != ST_RDATA),
        .adv    ((state == ST_RDATA) && sclk_fall && !sen_n),
        .limit  (tx_limit),
        .stream (rsp_buf),
        .bit_o  (tx_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (!sen_n) state_n = ST_CTRL;
            ST_CTRL: begin
                if (sen_n)          state_n = ST_IDLE;
                else if (ctrl_done) state_n = !dec.legal ? ST_SKIP :
                                              (dec.is_write ? ST_WDATA : ST_RDATA);
            end
            ST_WDATA: if (sen_n) state_n = ST_IDLE;
            ST_RDATA: if (sen_n) state_n = ST_IDLE;
            ST_SKIP:  if (sen_n) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // counters, mode latches and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_cnt   <= '0;
            wr_cnt     <= '0;
            use_alt_q  <= 1'b0;
            full_q     <= 1'b0;
            cmd_buf    <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            cmd_strobe <= commit;
            if (commit) cmd_buf <= cmd_sh;
            if (state == ST_IDLE) begin
                ctrl_cnt <= '0;
                wr_cnt   <= '0;
            end else begin
                if ((state == ST_CTRL) && rise_act) ctrl_cnt <= ctrl_cnt + 4'd1;
                if ((state == ST_WDATA) && rise_act && (wr_cnt <= WCW'(CMD_BITS)))
                    wr_cnt <= wr_cnt + 1'b1;
            end
            if (ctrl_done) begin
                use_alt_q <= dec.use_alt;
                full_q    <= dec.full_resp;
            end
        end
    end

    // outputs
    always_comb begin
        sdio_oe  = (state == ST_RDATA) && !use_alt_q;
        alt_oe   = (state == ST_RDATA) &&  use_alt_q;
        sdio_out = sdio_oe & tx_bit;
        alt_out  = alt_oe  & tx_bit;
    end

    AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && alt_oe)); // R8

    AST_OE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sen_n) |-> !(sdio_oe || alt_oe)); // R10

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe); // R3

    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(sen_n)); // R3

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sdio_oe) && sdio_oe && !$past(sclk_fall)) |-> $stable(sdio_out)); // R7

endmodule

// File: tb/tb_spi_cr_slave.sv
`timescale 1ns/1ps
module tb_spi_cr_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, alt_out, alt_oe, cmd_strobe;
    logic [127:0] rsp_buf;
    logic [63:0]  cmd_buf;

    always #2.5 clk = ~clk;

    spi_cr_slave dut (
        .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .rsp_buf(rsp_buf), .cmd_buf(cmd_buf), .cmd_strobe(cmd_strobe)
    );

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural model
    int   m_phase = 0;  // 0 idle, 1 ctrl, 2 write, 3 read, 4 skip
    int   m_ccnt = 0;
    int   m_code = 0;
    int   m_alt = 0;
    int   m_len = 0;
    int   m_idx = 0;
    logic exp_bit = 1'b0;
    logic exp_strobe = 1'b0;
    logic [63:0] exp_cmd = '0;
    logic wq[$];
    byte unsigned rbytes[16];

    function automatic logic stream_bit(int j);
        return rbytes[j / 8][7 - (j % 8)];
    endfunction

    task automatic note(string what, logic got, logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic tk();
        logic eo, ea;
        @(negedge clk);
        eo = (m_phase == 3) && (m_alt == 0);
        ea = (m_phase == 3) && (m_alt == 1);
        note("sdio_oe", sdio_oe, eo);
        note("alt_oe", alt_oe, ea);
        note("sdio_out", sdio_out, eo & exp_bit);
        note("alt_out", alt_out, ea & exp_bit);
        note("cmd_strobe", cmd_strobe, exp_strobe);
        tests++;
        if (cmd_buf !== exp_cmd) begin
            fails++;
            $display("FAIL %s cmd_buf got %h expected %h", cur_req, cmd_buf, exp_cmd);
        end
        exp_strobe = 1'b0;
    endtask

    task automatic tks(int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic m_rise(logic b);
        if (sen_n) return;  // R11, R10: edges while deselected ignored
        if (m_phase == 1) begin
            m_code = ((m_code << 1) | b) & 8'hFF;
            m_ccnt++;
            if (m_ccnt == 8) begin
                m_idx = 0;
                exp_bit = 1'b0;
                case (m_code)
                    8'h48: m_phase = 2;
                    8'h80: begin m_phase = 3; m_alt = 0; m_len = 8;   end
                    8'hC0: begin m_phase = 3; m_alt = 0; m_len = 128; end
                    8'hA0: begin m_phase = 3; m_alt = 1; m_len = 8;   end
                    8'hE0: begin m_phase = 3; m_alt = 1; m_len = 128; end
                    default: m_phase = 4;
                endcase
            end
        end else if (m_phase == 2) begin
            wq.push_back(b);
        end
    endtask

    task automatic m_fall();
        if (sen_n || m_phase != 3) return;
        if (m_idx < m_len) begin
            exp_bit = stream_bit(m_idx);
            m_idx++;
        end else exp_bit = 1'b0;
    endtask

    task automatic send_bit(logic b);
        sdio_in = b;
        tks(2);
        sclk = 1'b1; m_rise(b);
        tks(3);
        sclk = 1'b0; m_fall();
        tks(1);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic start_tx();
        sen_n = 1'b0;
        if (m_phase == 0) begin
            m_phase = 1; m_ccnt = 0; m_code = 0;
            wq.delete();
        end
        tks(2);
    endtask

    task automatic m_end();
        if (m_phase == 2 && wq.size() == 64) begin
            exp_strobe = 1'b1;
            exp_cmd = '0;
            foreach (wq[k]) exp_cmd = {exp_cmd[62:0], wq[k]};
        end
        m_phase = 0;
        exp_bit = 1'b0;
    endtask

    task automatic end_tx();
        sen_n = 1'b1; m_end();
        tks(3);
    endtask

    // SEN high and SCLK rise in the same clock
    task automatic end_with_rise(logic b);
        sdio_in = b;
        tks(2);
        sen_n = 1'b1; sclk = 1'b1; m_end();
        tks(3);
        sclk = 1'b0;
        tks(3);
    endtask

    task automatic write_bytes(int n, int seed);
        for (int i = 0; i < n; i++) send_byte(8'((seed * 37 + i * 29 + 5) & 8'hFF));
    endtask

    task automatic read_tx(logic [7:0] code, int nbits);
        start_tx();
        send_byte(code);
        for (int i = 0; i < nbits; i++) send_bit(1'b0);
        end_tx();
    endtask

    task automatic set_resp(int seed);
        for (int i = 0; i < 16; i++) rbytes[i] = 8'((seed * 53 + i * 17 + 3) & 8'hFF);
        for (int i = 0; i < 16; i++) rsp_buf[127 - 8*i -: 8] = rbytes[i];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        set_resp(1);
        cur_req = "R1";
        tks(3);
        rst_n = 1'b1;
        tks(3);

        cur_req = "R3";  // also R2: control capture
        start_tx(); send_byte(8'h48); write_bytes(8, 1); end_tx();

        cur_req = "R5";
        read_tx(8'h80, 10);
        set_resp(2);
        read_tx(8'hC0, 130);

        cur_req = "R6";  // enables per R8
        read_tx(8'hA0, 10);
        set_resp(3);
        read_tx(8'hE0, 130);

        cur_req = "R4";
        start_tx(); send_byte(8'h48); write_bytes(7, 2); end_tx();
        start_tx(); send_byte(8'h48); write_bytes(9, 3); end_tx();
        start_tx(); send_byte(8'h48); end_tx();

        cur_req = "R9";
        start_tx(); send_byte(8'h55); write_bytes(4, 4); end_tx();
        start_tx(); send_byte(8'hC1); write_bytes(2, 5); end_tx();

        cur_req = "R10";
        start_tx(); send_byte(8'hC0);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        end_tx();
        start_tx(); send_byte(8'h48); write_bytes(8, 6); end_with_rise(1'b1);
        start_tx(); send_byte(8'h48); write_bytes(7, 7);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        end_with_rise(1'b0);
        start_tx(); send_byte(8'h4); end_tx();

        cur_req = "R11";
        for (int i = 0; i < 16; i++) send_bit(i[0]);

        cur_req = "R7";
        set_resp(9);
        read_tx(8'h80, 12);
        start_tx(); send_byte(8'h48); write_bytes(8, 11); end_tx();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule